// File: doc/BRIEF.md
# Main Clock Loss Monitor

This block watches an external main oscillator clock with a free-running internal oscillator clock. While monitoring is active, it counts internal-clock cycles that pass without a main-clock edge. When that count reaches a fixed limit, it raises a one-cycle reset request. Software turns the monitor on with an enable bit. No pin carries a data stream, so every interface here is a plain level or pulse signal.

Monitoring is suspended in three cases, with no software action needed:
- while the device is in STOP mode;
- while software holds the main oscillator stopped;
- during the oscillation stabilization window that follows each restart of the oscillator.

When the window ends, monitoring re-arms by itself if the enable bit is still 1. A small mode state machine in the internal-clock domain decides when the monitor may run. A toggle flop in the main-clock domain, read through a synchronizer, provides the edge evidence.

Top module: `clkmon_top`

## Requirements
- R1: After reset, `mon_active` and `loss_rst` are 0 and the enable bit is 0.
- R2: Writing 1 to bit 0 at address 0 sets the enable bit. `mon_active` is 1 only while the enable bit is 1 and the oscillator is stable. Writing 0 to bit 0 clears `mon_active` after that write's clock edge. While `mon_active` is 0, `loss_rst` stays 0 even with no main-clock edges.
- R3: A `stop_req` pulse sampled at a clock edge clears `mon_active` from the next edge. It stays 0 until `wake` is sampled, whatever the enable bit is.
- R4: The effective oscillator-stop bit is chosen by `cpu_on_sub`:
  - when `cpu_on_sub` is 0, it is bit 7 at address 1;
  - when `cpu_on_sub` is 1, it is bit 7 at address 2.

  While the effective bit is 1, `mon_active` is 0 from the second edge after the write. Setting the non-selected bit has no effect on `mon_active`.
- R5: The stabilization window lasts 2^n internal-clock cycles. After `wake` is sampled at edge E, `mon_active` stays 0 up to edge E+2^n−1 and becomes 1 at edge E+2^n. After the effective stop bit is cleared by a write at edge W, `mon_active` becomes 1 at edge W+1+2^n.
- R6: Bits 2:0 at address 3 select n. Codes 0 to 7 give base values 11, 13, 14, 15, 16, 17, 18, 18, minus the parameter `STAB_EXP_BIAS`. The reset code is 4.
- R7: If the enable bit was 1 before STOP, monitoring resumes after the stabilization window with no register write.
- R8: If the enable bit is written to 1 while the oscillator is held stopped, `mon_active` stays 0 until the window that follows the oscillator restart has ended.
- R9: While `mon_active` is 1, each run of `LOSS_LIMIT` consecutive internal cycles with no detected main-clock edge produces a one-cycle `loss_rst` pulse. Pulses repeat every `LOSS_LIMIT` cycles while edges stay absent. A running main clock produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Free-running internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_main | input | 1 | Main oscillator clock being watched |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 enable, 1 and 2 oscillator stop, 3 stabilization select) |
| cfg_wdata | input | 8 | Register write data |
| cpu_on_sub | input | 1 | CPU clock source is the subsystem clock |
| stop_req | input | 1 | STOP-mode entry pulse |
| wake | input | 1 | STOP-release pulse |
| mon_active | output | 1 | Monitoring currently active |
| loss_rst | output | 1 | One-cycle clock-loss reset request |

## Verification
The bench builds the block with `STAB_EXP_BIAS` = 9 and `LOSS_LIMIT` = 4. This maps the eight select codes to windows of 4 to 512 cycles. With windows that short, every code can be swept through the STOP path with an exact edge count on re-arm. Both oscillator-stop sources are exercised, and the loss pulse count over a fixed window is checked against the period that `LOSS_LIMIT` implies.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_OFF  = 2'd2,
    MODE_STAB = 2'd3
  } mode_e;

  localparam int unsigned STAB_EXP_MAX = 18;

  function automatic int unsigned stab_exp_base(input logic [2:0] code);
    case (code)
      3'd0:    return 11;
      3'd1:    return 13;
      3'd2:    return 14;
      3'd3:    return 15;
      3'd4:    return 16;
      3'd5:    return 17;
      default: return 18;
    endcase
  endfunction

endpackage

// File: rtl/clkmon_regs.sv
module clkmon_regs (
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       cpu_on_sub,
  output logic       mon_en,
  output logic       osc_off,
  output logic [2:0] stab_code
);
  logic halt_int_q, halt_sub_q;
  logic unused_wdata;
  assign unused_wdata = &{1'b0, cfg_wdata[6:3]};

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      mon_en     <= 1'b0;
      halt_int_q <= 1'b0;
      halt_sub_q <= 1'b0;
      stab_code  <= 3'd4;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: mon_en     <= cfg_wdata[0];
        2'd1: halt_int_q <= cfg_wdata[7];
        2'd2: halt_sub_q <= cfg_wdata[7];
        default: stab_code <= cfg_wdata[2:0];
      endcase
    end
  end

  assign osc_off = cpu_on_sub ? halt_sub_q : halt_int_q;

  a_r1_reset_disabled: assert property (@(posedge clk_int)
    $rose(rst_n) |-> !mon_en);
endmodule

// File: rtl/clkmon_mode_fsm.sv
module clkmon_mode_fsm
  import clkmon_pkg::*;
#(
  parameter int unsigned STAB_EXP_BIAS = 0
) (
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       osc_off,
  input  logic [2:0] stab_code,
  output logic       osc_stable
);
  localparam int unsigned CW = STAB_EXP_MAX - STAB_EXP_BIAS + 1;

  mode_e          state_q, state_d;
  logic [CW-1:0]  cnt_q, limit;
  logic           stab_done;

  always_comb begin
    limit = ({{(CW-1){1'b0}}, 1'b1} << (stab_exp_base(stab_code) - STAB_EXP_BIAS)) - 1'b1;
  end
  assign stab_done = (cnt_q == limit);

  always_comb begin
    state_d = state_q;
    case (state_q)
      MODE_RUN:  if (stop_req) state_d = MODE_HALT;
                 else if (osc_off) state_d = MODE_OFF;
      MODE_HALT: if (wake) state_d = MODE_STAB;
      MODE_OFF:  if (stop_req) state_d = MODE_HALT;
                 else if (!osc_off) state_d = MODE_STAB;
      default:   if (stop_req) state_d = MODE_HALT;
                 else if (osc_off) state_d = MODE_OFF;
                 else if (stab_done) state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_STAB;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != MODE_STAB) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign osc_stable = (state_q == MODE_RUN);

  // R5: the stable state is only ever entered from a completed window
  a_r5_run_after_window: assert property (@(posedge clk_int) disable iff (!rst_n)
    (state_q == MODE_RUN) && ($past(state_q) != MODE_RUN)
      |-> ($past(state_q) == MODE_STAB) && $past(stab_done));

  // R3: STOP holds until wake
  a_r3_halt_holds: assert property (@(posedge clk_int) disable iff (!rst_n)
    (state_q == MODE_HALT) && !wake |=> (state_q == MODE_HALT));
endmodule

// File: rtl/clkmon_edge_watch.sv
module clkmon_edge_watch #(
  parameter int unsigned LOSS_LIMIT  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic rst_n,
  input  logic clk_main,
  input  logic active,
  output logic loss_rst
);
  localparam int unsigned LW = $clog2(LOSS_LIMIT + 1);

  logic                   tgl_q;
  logic [SYNC_STAGES:0]   sync_q;
  logic                   edge_seen;
  logic [LW-1:0]          gap_q;

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n)      sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= tgl_q;
        else             sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      loss_rst <= 1'b0;
    end else if (!active || edge_seen) begin
      gap_q    <= '0;
      loss_rst <= 1'b0;
    end else if (gap_q == LW'(LOSS_LIMIT - 1)) begin
      gap_q    <= '0;
      loss_rst <= 1'b1;
    end else begin
      gap_q    <= gap_q + 1'b1;
      loss_rst <= 1'b0;
    end
  end

  // R9: the request is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk_int) disable iff (!rst_n)
    loss_rst |=> !loss_rst);
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top #(
  parameter int unsigned STAB_EXP_BIAS = 0,
  parameter int unsigned LOSS_LIMIT    = 4
) (
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       clk_main,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       cpu_on_sub,
  input  logic       stop_req,
  input  logic       wake,
  output logic       mon_active,
  output logic       loss_rst
);
  logic       mon_en, osc_off, osc_stable;
  logic [2:0] stab_code;

  clkmon_regs u_regs (
    .clk_int(clk_int), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_on_sub(cpu_on_sub), .mon_en(mon_en),
    .osc_off(osc_off), .stab_code(stab_code)
  );

  clkmon_mode_fsm #(.STAB_EXP_BIAS(STAB_EXP_BIAS)) u_fsm (
    .clk_int(clk_int), .rst_n(rst_n), .stop_req(stop_req), .wake(wake),
    .osc_off(osc_off), .stab_code(stab_code), .osc_stable(osc_stable)
  );

  assign mon_active = osc_stable & mon_en;

  clkmon_edge_watch #(.LOSS_LIMIT(LOSS_LIMIT)) u_watch (
    .clk_int(clk_int), .rst_n(rst_n), .clk_main(clk_main),
    .active(mon_active), .loss_rst(loss_rst)
  );

  a_r2_no_loss_when_idle: assert property (@(posedge clk_int) disable iff (!rst_n)
    !mon_active |=> !loss_rst);
  a_r3_stop_suspends: assert property (@(posedge clk_int) disable iff (!rst_n)
    stop_req |=> !mon_active);
  a_r4_osc_off_suspends: assert property (@(posedge clk_int) disable iff (!rst_n)
    osc_off |=> !mon_active);
endmodule

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;
  localparam int unsigned BIAS  = 9;
  localparam int unsigned LIMIT = 4;

  logic clk_int = 1'b0, clk_main = 1'b0, main_run = 1'b1, rst_n = 1'b0;
  logic cfg_we = 1'b0, cpu_on_sub = 1'b0, stop_req = 1'b0, wake = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic mon_active, loss_rst;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_int = ~clk_int;
  always #5 if (main_run) clk_main = ~clk_main;

  clkmon_top #(.STAB_EXP_BIAS(BIAS), .LOSS_LIMIT(LIMIT)) dut_i (
    .clk_int(clk_int), .rst_n(rst_n), .clk_main(clk_main), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cpu_on_sub(cpu_on_sub),
    .stop_req(stop_req), .wake(wake), .mon_active(mon_active), .loss_rst(loss_rst)
  );

  function automatic int unsigned win(input int unsigned code);
    int unsigned base;
    base = (code == 0) ? 11 : (code >= 6) ? 18 : 12 + code;
    return 1 << (base - BIAS);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_int);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk_int); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk_int); stop_req = 1'b1;
    @(posedge clk_int); #1; stop_req = 1'b0;
  endtask

  // waits edges after an event edge, checking the exact re-arm edge
  task automatic expect_rearm(input string req, input int unsigned edges_to_on);
    for (int k = 1; k < edges_to_on; k++) @(posedge clk_int);
    @(negedge clk_int); chk(req, mon_active, 1'b0);
    @(posedge clk_int);
    @(negedge clk_int); chk(req, mon_active, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_int);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pulses;
    logic prev;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk_int);
    chk("R1 mon_active", mon_active, 1'b0);
    chk("R1 loss_rst", loss_rst, 1'b0);
    idle(win(4) + 5);
    chk("R1 enable cleared", mon_active, 1'b0);

    wr(2'd0, 8'h01);
    @(negedge clk_int); chk("R2 enable on", mon_active, 1'b1);
    wr(2'd0, 8'h00);
    @(negedge clk_int); chk("R2 enable off", mon_active, 1'b0);
    main_run = 1'b0;
    pulses = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk_int); if (loss_rst) pulses++; end
    checks++;
    if (pulses != 0) begin fails++; $display("FAIL R2 pulses actual=%0d expected=0", pulses); end
    main_run = 1'b1;
    wr(2'd0, 8'h01);

    // R6 sweep of every select code through the STOP path (R3, R5, R7)
    for (int c = 0; c < 8; c++) begin
      wr(2'd3, 8'(c));
      pulse_stop();
      @(negedge clk_int); chk("R3 stop", mon_active, 1'b0);
      main_run = 1'b0;
      idle(10);
      chk("R3 held", mon_active, 1'b0);
      main_run = 1'b1;
      @(negedge clk_int); wake = 1'b1;
      @(posedge clk_int); #1; wake = 1'b0;
      expect_rearm("R5 R6 R7 rearm", win(c));
    end

    // R4 and R8 for both clock sources, select code 1
    wr(2'd3, 8'h01);
    for (int s = 0; s < 2; s++) begin
      cpu_on_sub = s[0];
      @(negedge clk_int);
      wr(s ? 2'd1 : 2'd2, 8'h80);
      idle(3);
      chk("R4 other bit ignored", mon_active, 1'b1);
      wr(s ? 2'd1 : 2'd2, 8'h00);
      wr(s ? 2'd2 : 2'd1, 8'h80);
      @(negedge clk_int); chk("R4 one edge later", mon_active, 1'b1);
      @(negedge clk_int); chk("R4 suspended", mon_active, 1'b0);
      main_run = 1'b0;
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h01);
      idle(8);
      chk("R8 held off", mon_active, 1'b0);
      main_run = 1'b1;
      wr(s ? 2'd2 : 2'd1, 8'h00);
      expect_rearm("R5 R8 rearm", 1 + win(1));
    end

    // R9 loss pulses
    pulses = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk_int); if (loss_rst) pulses++; end
    checks++;
    if (pulses != 0) begin fails++; $display("FAIL R9 running pulses actual=%0d expected=0", pulses); end
    main_run = 1'b0;
    idle(8);
    pulses = 0; prev = 1'b0;
    for (int k = 0; k < 10 * LIMIT; k++) begin
      @(negedge clk_int);
      if (loss_rst) pulses++;
      if (loss_rst && prev) begin
        checks++; fails++; $display("FAIL R9 width actual=2 expected=1");
      end
      prev = loss_rst;
    end
    checks++;
    if (pulses != 10) begin fails++; $display("FAIL R9 pulses actual=%0d expected=10", pulses); end
    main_run = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule